// File: doc/BRIEF.md
# BCD Clock Register File

This block keeps calendar time as seven binary-coded-decimal registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A byte-wide register port lets software read and set each field. A single-cycle `tick` pulse, one per second, advances the calendar. The carries run from seconds to minutes to hours to days, and from there through months of the correct length to the year.

Writes are checked field by field. A value that is not valid BCD, or that lies outside the field's range, is dropped and the register keeps its contents. The seconds byte carries a stop flag in its top bit that freezes timekeeping. The day-of-week byte carries one stored flag. A separate control byte always has certain bits forced when it is written. The two-digit year is an offset from the parameter `BASE_YEAR`, and leap years are derived from that base.

Top module: `bcd_clock_regs`

## Requirements
- R1: Register index map on `addr`: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 day of month, 6 month, 7 year. After reset the reads are 0x90, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01 and 0x00 in that index order.
- R2: A write to seconds loads `wr_data[6:0]` only if it is valid BCD from 00 to 59. `wr_data[7]` is always stored as the stop flag. A read of seconds returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R3: While the stop flag is set, ticks change no time field. When the flag is cleared, counting resumes from the frozen value.
- R4: Minutes take bits 6:0 (valid 00..59), hours bits 5:0 (00..23), day of month bits 5:0 (01..31), month bits 4:0 (01..12), and year all 8 bits (00..99). A value that is outside its range or is not valid BCD (a nibble above 9) leaves the field unchanged.
- R5: A write to day of week loads bits 2:0 as the day and keeps bit 6 as a stored flag. A read returns the flag in bit 6 and the day in bits 2:0, with the other bits zero.
- R6: A write to control stores `(wr_data & ~0xA0) | 0x90`.
- R7: A tick with the stop flag clear and no write in the same cycle advances seconds by one. 59 wraps to 00 and carries into minutes, and minutes carry into hours the same way; hours wrap from 23 to 00.
- R8: On the carry out of hours, day of week steps 1..7 and wraps to 1. Day of month passes the last day of the month to 01 and carries into month. Month 12 wraps to 01 and carries into year, and year 99 wraps to 00.
- R9: February has 29 days when `BASE_YEAR` plus the binary year is divisible by 4, and 28 days otherwise. April, June, September and November have 30 days, and the rest have 31.
- R10: A write is visible on the next cycle and leaves every other field unchanged. A tick that arrives in the same cycle as any write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance pulse |
| wr_en | input | 1 | Write strobe for the indexed register |
| addr | input | 3 | Register index for read and write |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Combinational read of the indexed register |

## Verification
The hardest conditions to reach from the ports are the end-of-period carries: the end of February in leap and non-leap years, a 30-day month, and the end of year 99. Counting ticks to reach them would take tens of millions of cycles. The stimulus instead writes every field to one second before the boundary and then applies a single tick, which moves the ripple through all seven fields in one cycle. The stop flag is exercised with an out-of-range seconds byte, so that only the flag changes. A tick is also applied in the same cycle as a write to show that the tick is dropped.

// File: rtl/bcd_clock_regs.sv
module bcd_clock_regs #(
  parameter int BASE_YEAR = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam logic [2:0] A_CTRL = 3'd0, A_SEC = 3'd1, A_MIN = 3'd2, A_HR = 3'd3,
                         A_WDAY = 3'd4, A_MDAY = 3'd5, A_MON = 3'd6, A_YR = 3'd7;
  localparam logic [1:0] BASE_MOD = 2'(BASE_YEAR % 4);

  logic [7:0] ctrl_q, sec_q, min_q, hr_q, wday_q, mday_q, mon_q, yr_q;
  logic       stop_q, flag_q;

  function automatic logic bcd_in(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic [6:0] yr_bin;
  logic       leap;
  logic [7:0] last_day;
  assign yr_bin = {3'd0, yr_q[7:4]} * 7'd10 + {3'd0, yr_q[3:0]};
  assign leap   = (yr_bin[1:0] + BASE_MOD) == 2'd0;

  always_comb begin
    case (mon_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  logic adv, sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;
  assign adv      = tick && !stop_q && !wr_en;
  assign sec_wrap = sec_q == 8'h59;
  assign min_wrap = min_q == 8'h59;
  assign hr_wrap  = hr_q == 8'h23;
  assign day_wrap = mday_q >= last_day;
  assign mon_wrap = mon_q == 8'h12;

  logic [7:0] d7, d6, d5;
  assign d7 = {1'b0, wr_data[6:0]};
  assign d6 = {2'b0, wr_data[5:0]};
  assign d5 = {3'b0, wr_data[4:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 8'h90;
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hr_q   <= 8'h00;
      wday_q <= 8'h01;
      mday_q <= 8'h01;
      mon_q  <= 8'h01;
      yr_q   <= 8'h00;
      stop_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: ctrl_q <= (wr_data & ~8'hA0) | 8'h90;
        A_SEC: begin
          stop_q <= wr_data[7];
          if (bcd_in(d7, 8'h00, 8'h59)) sec_q <= d7;
        end
        A_MIN:  if (bcd_in(d7, 8'h00, 8'h59)) min_q <= d7;
        A_HR:   if (bcd_in(d6, 8'h00, 8'h23)) hr_q <= d6;
        A_WDAY: begin
          wday_q <= {5'd0, wr_data[2:0]};
          flag_q <= wr_data[6];
        end
        A_MDAY: if (bcd_in(d6, 8'h01, 8'h31)) mday_q <= d6;
        A_MON:  if (bcd_in(d5, 8'h01, 8'h12)) mon_q <= d5;
        default: if (bcd_in(wr_data, 8'h00, 8'h99)) yr_q <= wr_data;
      endcase
    end else if (adv) begin
      sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (sec_wrap) begin
        min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
        if (min_wrap) begin
          hr_q <= hr_wrap ? 8'h00 : bcd_inc(hr_q);
          if (hr_wrap) begin
            wday_q <= (wday_q >= 8'h07) ? 8'h01 : wday_q + 8'h01;
            mday_q <= day_wrap ? 8'h01 : bcd_inc(mday_q);
            if (day_wrap) begin
              mon_q <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
              if (mon_wrap) yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = ctrl_q;
      A_SEC:   rd_data = sec_q | {stop_q, 7'd0};
      A_MIN:   rd_data = min_q;
      A_HR:    rd_data = hr_q;
      A_WDAY:  rd_data = wday_q | {1'b0, flag_q, 6'd0};
      A_MDAY:  rd_data = mday_q;
      A_MON:   rd_data = mon_q;
      default: rd_data = yr_q;
    endcase
  end

  p_sec_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[3:0] <= 4'd9 && sec_q[7:4] <= 4'd5);

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> $stable({sec_q, min_q, hr_q, wday_q, mday_q, mon_q, yr_q}));

  p_month_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mon_q >= 8'h01 && mon_q <= 8'h12);

  p_ctrl_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);

  p_tick_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop_q && !wr_en) |=> sec_q != $past(sec_q));

  p_mday_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mday_q != 8'h00);

  p_write_drops_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_SEC) |=> $stable(sec_q));
endmodule

// File: tb/bcd_clock_regs_tb.sv
module bcd_clock_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  bcd_clock_regs #(.BASE_YEAR(2000)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  typedef struct {
    logic [2:0] a;
    logic [7:0] e;
    string      tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_vec++;
      if (rd_data !== it.e) begin
        n_bad++;
        $display("FAIL %s idx %0d: got %h expected %h", it.tag, it.a, rd_data, it.e);
      end
    end
  end

  task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic t);
    @(posedge clk); #1;
    wr_en = w; addr = a; wr_data = d; tick = t;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b1);
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    cyc(1'b0, a, 8'd0, 1'b0);
    it.a = a; it.e = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(3'd3, h); wr(3'd2, m); wr(3'd1, s);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(3'd0, 8'h90, "R1"); chk(3'd1, 8'h00, "R1"); chk(3'd2, 8'h00, "R1");
    chk(3'd3, 8'h00, "R1"); chk(3'd4, 8'h01, "R1"); chk(3'd5, 8'h01, "R1");
    chk(3'd6, 8'h01, "R1"); chk(3'd7, 8'h00, "R1");

    // R2 seconds write and range
    wr(3'd1, 8'h45); chk(3'd1, 8'h45, "R2");
    wr(3'd1, 8'h60); chk(3'd1, 8'h45, "R2");
    wr(3'd1, 8'h1A); chk(3'd1, 8'h45, "R2");

    // R3 stop flag freezes and resumes
    wr(3'd1, 8'h30); tk(3); chk(3'd1, 8'h33, "R7");
    wr(3'd1, 8'hFF); chk(3'd1, 8'hB3, "R3");
    tk(5); chk(3'd1, 8'hB3, "R3");
    wr(3'd1, 8'h7F); chk(3'd1, 8'h33, "R3");
    tk(1); chk(3'd1, 8'h34, "R3");

    // R4 field ranges
    wr(3'd3, 8'h24); chk(3'd3, 8'h00, "R4");
    wr(3'd3, 8'hC5); chk(3'd3, 8'h05, "R4");
    wr(3'd2, 8'h5A); chk(3'd2, 8'h00, "R4");
    wr(3'd5, 8'h00); chk(3'd5, 8'h01, "R4");
    wr(3'd5, 8'h32); chk(3'd5, 8'h01, "R4");
    wr(3'd6, 8'h13); chk(3'd6, 8'h01, "R4");
    wr(3'd6, 8'h00); chk(3'd6, 8'h01, "R4");
    wr(3'd6, 8'h0C); chk(3'd6, 8'h01, "R4");
    wr(3'd7, 8'hA0); chk(3'd7, 8'h00, "R4");
    wr(3'd7, 8'h99); chk(3'd7, 8'h99, "R4");

    // R5 weekday and flag
    wr(3'd4, 8'h45); chk(3'd4, 8'h45, "R5");
    wr(3'd4, 8'hBF); chk(3'd4, 8'h07, "R5");

    // R6 control forcing
    wr(3'd0, 8'hFF); chk(3'd0, 8'hDF, "R6");
    wr(3'd0, 8'h00); chk(3'd0, 8'h90, "R6");
    wr(3'd0, 8'h2B); chk(3'd0, 8'h9B, "R6");

    // R7 minute carry without hour carry
    set_time(8'h07, 8'h10, 8'h59); tk(1);
    chk(3'd1, 8'h00, "R7"); chk(3'd2, 8'h11, "R7"); chk(3'd3, 8'h07, "R7");

    // R8 / R9 end of February, non-leap year (2023)
    wr(3'd7, 8'h23); wr(3'd6, 8'h02); wr(3'd5, 8'h28); wr(3'd4, 8'h47);
    set_time(8'h23, 8'h59, 8'h59); tk(1);
    chk(3'd1, 8'h00, "R8"); chk(3'd2, 8'h00, "R8"); chk(3'd3, 8'h00, "R8");
    chk(3'd4, 8'h41, "R8"); chk(3'd5, 8'h01, "R9"); chk(3'd6, 8'h03, "R9");
    chk(3'd7, 8'h23, "R8");

    // R9 leap year (2024)
    wr(3'd7, 8'h24); wr(3'd6, 8'h02); wr(3'd5, 8'h28);
    set_time(8'h23, 8'h59, 8'h59); tk(1);
    chk(3'd5, 8'h29, "R9"); chk(3'd6, 8'h02, "R9");
    set_time(8'h23, 8'h59, 8'h59); tk(1);
    chk(3'd5, 8'h01, "R9"); chk(3'd6, 8'h03, "R9");

    // R9 thirty-day month
    wr(3'd6, 8'h04); wr(3'd5, 8'h30);
    set_time(8'h23, 8'h59, 8'h59); tk(1);
    chk(3'd5, 8'h01, "R9"); chk(3'd6, 8'h05, "R9");

    // R8 end of year 99
    wr(3'd7, 8'h99); wr(3'd6, 8'h12); wr(3'd5, 8'h31); wr(3'd4, 8'h03);
    set_time(8'h23, 8'h59, 8'h59); tk(1);
    chk(3'd5, 8'h01, "R8"); chk(3'd6, 8'h01, "R8"); chk(3'd7, 8'h00, "R8");
    chk(3'd4, 8'h04, "R8"); chk(3'd3, 8'h00, "R8");

    // R10 tick with a write is dropped; other fields untouched
    wr(3'd1, 8'h10);
    cyc(1'b1, 3'd2, 8'h05, 1'b1);
    chk(3'd1, 8'h10, "R10"); chk(3'd2, 8'h05, "R10"); chk(3'd3, 8'h00, "R10");
    cyc(1'b1, 3'd1, 8'h20, 1'b1);
    chk(3'd1, 8'h20, "R10");
    tk(1); chk(3'd1, 8'h21, "R10");

    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule